// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of an asynchronous parallel flash bus and carries out complete erase and program operations on its own. A client hands it one operation code, a target address and a 16-bit data word over a valid/ready handshake. The sequencer then writes the unlock and command cycles the flash expects. It polls the target location until bit 7 reports that the internal operation has finished, and reads the word once more to confirm the result. At the end it reports success, a failed confirmation, or a polling timeout.

Every write cycle keeps output enable high and pulses write enable low. The low and high widths, the data setup and the address hold are given in nanoseconds and converted to clock counts from the clock period parameter. Read cycles hold chip and output enable low for the access time before the data is sampled. Only one operation is in flight at a time.

Top module: `nor_flash_seq`

## Requirements
- R1: Operation code 0 (word program) issues exactly four writes, in this order: 0x00AA to 0x5555, 0x0055 to 0x2AAA, 0x00A0 to 0x5555, then the request data to the request address.
- R2: Operation code 1 (sector erase) issues exactly six writes, in this order: 0x00AA to 0x5555, 0x0055 to 0x2AAA, 0x0080 to 0x5555, 0x00AA to 0x5555, 0x0055 to 0x2AAA, then 0x0030 to the request address.
- R3: Operation code 2 (chip erase) issues the same first five writes as R2, with 0x0010 to 0x5555 as the sixth.
- R4: In every write, chip enable is low and output enable is high. Write enable stays low for at least max(ceil(WP_NS/CLK_NS), ceil(DS_NS/CLK_NS)) cycles. Address and data stay constant from the falling edge of write enable until at least max(ceil(WPH_NS/CLK_NS), ceil(AH_NS/CLK_NS)) cycles after its rising edge, and write enable stays high that long before it falls again.
- R5: After the command writes, the sequencer reads the request address repeatedly until bit 7 of the read word equals bit 7 of the request data (program) or equals 1 (either erase).
- R6: Once polling succeeds, exactly one further read of the request address follows. If the full word equals the request data (program) or 0xFFFF (erase), rsp_done pulses for one cycle; otherwise rsp_err pulses for one cycle. The two never pulse together.
- R7: If POLL_LIMIT poll reads all fail the bit-7 test, the operation ends with rsp_err and rsp_timeout pulsing together, and no confirming read is made.
- R8: req_ready is low from the cycle after an operation is accepted until its response pulse. Requests presented in that window are ignored and start no bus activity.
- R9: Operation code 3 is rejected: it makes rsp_err pulse in the cycle after acceptance, with rsp_timeout low and no bus cycle.
- R10: While rst_n is low, chip, output and write enable are high, the data bus is not driven, req_ready is high and no response pulses. A reset in the middle of an operation abandons it.
- R11: In every read, chip and output enable are low, write enable is high and the data bus is not driven, for at least ceil(ACC_NS/CLK_NS) cycles before the data is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 invalid |
| req_addr | input | AW | Target word address or sector address |
| req_data | input | DW | Word to program |
| rsp_done | output | 1 | One-cycle pulse: operation confirmed |
| rsp_err | output | 1 | One-cycle pulse: mismatch, timeout or invalid code |
| rsp_timeout | output | 1 | One-cycle pulse with rsp_err when polling gave up |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_o | output | DW | Flash write data |
| fl_dq_oe | output | 1 | Drive fl_dq_o onto the data bus |
| fl_dq_i | input | DW | Flash read data |

## Verification
A wrong command step index shows at the flash pins within one write cycle, as a wrong address or data value latched at a write-enable edge, or as a wrong number of writes before the first read. A poll counter or bit-7 comparison in the wrong state shows as a read count that differs from the busy period plus two, or as a premature timeout. Such an error becomes visible at the response pins no later than one read cycle after the flash stops reporting busy. A bus-phase counter that is off by one shortens a pulse width, and that is caught at the edge that closes the pulse.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_BAD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_POLL,
    ST_VERIFY
  } seq_st_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW,
    PH_HOLD,
    PH_RD,
    PH_RREC
  } bus_ph_e;

  // Whole clock cycles covering a time in ns, never less than one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 16
) (
  input  op_e             op,
  input  logic [2:0]      step,
  input  logic [AW-1:0]   tgt_addr,
  input  logic [DW-1:0]   tgt_data,
  output logic [AW-1:0]   c_addr,
  output logic [DW-1:0]   c_data,
  output logic            c_last
);

  localparam logic [AW-1:0] ADDR_ODD = AW'(32'h5555);
  localparam logic [AW-1:0] ADDR_EVN = AW'(32'h2AAA);

  function automatic logic [DW-1:0] code(input logic [7:0] b);
    return DW'(b);
  endfunction

  always_comb begin
    c_addr = ADDR_ODD;
    c_data = code(8'hAA);
    unique case (step)
      3'd0: begin c_addr = ADDR_ODD; c_data = code(8'hAA); end
      3'd1: begin c_addr = ADDR_EVN; c_data = code(8'h55); end
      3'd2: begin
        c_addr = ADDR_ODD;
        c_data = (op == OP_PROG) ? code(8'hA0) : code(8'h80);
      end
      3'd3: begin
        if (op == OP_PROG) begin
          c_addr = tgt_addr;
          c_data = tgt_data;
        end else begin
          c_addr = ADDR_ODD;
          c_data = code(8'hAA);
        end
      end
      3'd4: begin c_addr = ADDR_EVN; c_data = code(8'h55); end
      default: begin
        if (op == OP_SECT) begin
          c_addr = tgt_addr;
          c_data = code(8'h30);
        end else begin
          c_addr = ADDR_ODD;
          c_data = code(8'h10);
        end
      end
    endcase
  end

  assign c_last = (op == OP_PROG) ? (step == 3'd3) : (step == 3'd5);

endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_seq_pkg::*;
#(
  parameter int unsigned AW      = 18,
  parameter int unsigned DW      = 16,
  parameter int unsigned SETUP_C = 2,
  parameter int unsigned LOW_C   = 12,
  parameter int unsigned HIGH_C  = 12,
  parameter int unsigned RD_C    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic          idle,
  output logic [DW-1:0] rdata,
  output logic          f_ce_n,
  output logic          f_oe_n,
  output logic          f_we_n,
  output logic [AW-1:0] f_addr,
  output logic [DW-1:0] f_dq_o,
  output logic          f_dq_oe,
  input  logic [DW-1:0] f_dq_in
);

  localparam int unsigned MAXC = max_u(max_u(SETUP_C, LOW_C), max_u(HIGH_C, RD_C));
  localparam int unsigned CW   = $clog2(MAXC + 2);

  bus_ph_e         ph;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   a_q;
  logic [DW-1:0]   d_q;
  logic            last;

  function automatic logic [CW-1:0] len_m1(input int unsigned n);
    return CW'(n - 1);
  endfunction

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      a_q   <= '0;
      d_q   <= '0;
      rdata <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (start) begin
            a_q <= addr;
            d_q <= wdata;
            if (is_rd) begin
              ph  <= PH_RD;
              cnt <= len_m1(RD_C);
            end else begin
              ph  <= PH_SETUP;
              cnt <= len_m1(SETUP_C);
            end
          end
        end
        PH_SETUP: begin
          if (last) begin ph <= PH_LOW; cnt <= len_m1(LOW_C); end
          else cnt <= cnt - 1'b1;
        end
        PH_LOW: begin
          if (last) begin ph <= PH_HOLD; cnt <= len_m1(HIGH_C); end
          else cnt <= cnt - 1'b1;
        end
        PH_HOLD: begin
          if (last) ph <= PH_IDLE;
          else cnt <= cnt - 1'b1;
        end
        PH_RD: begin
          if (last) begin
            rdata <= f_dq_in;
            ph    <= PH_RREC;
          end else cnt <= cnt - 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign done    = ((ph == PH_HOLD) && last) || (ph == PH_RREC);
  assign idle    = (ph == PH_IDLE);
  assign f_ce_n  = (ph == PH_IDLE);
  assign f_oe_n  = (ph != PH_RD);
  assign f_we_n  = (ph != PH_LOW);
  assign f_dq_oe = (ph == PH_SETUP) || (ph == PH_LOW) || (ph == PH_HOLD);
  assign f_addr  = a_q;
  assign f_dq_o  = d_q;

  // Run-length counters of the strobes, for the width checks below.
  logic [CW-1:0] we_lo_run, oe_lo_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_lo_run <= '0;
      oe_lo_run <= '0;
    end else begin
      we_lo_run <= f_we_n ? '0 : we_lo_run + 1'b1;
      oe_lo_run <= f_oe_n ? '0 : oe_lo_run + 1'b1;
    end
  end

  assert_we_low_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_we_n) |-> (we_lo_run >= CW'(LOW_C)));

  assert_bus_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_ce_n && !done) |=> ($stable(f_addr) && $stable(f_dq_o)));

  assert_read_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_oe_n) |-> (oe_lo_run >= CW'(RD_C)));

  assert_read_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_oe_n) |=> (!f_dq_oe && f_we_n));

endmodule

// File: rtl/flash_poll_ctl.sv
module flash_poll_ctl #(
  parameter int unsigned LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic rd_done,
  input  logic rd_b7,
  input  logic exp_b7,
  output logic hit,
  output logic expire
);

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] miss_cnt;

  assign hit    = rd_done && (rd_b7 == exp_b7);
  assign expire = rd_done && !hit && (miss_cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) miss_cnt <= '0;
    else if (rd_done && !hit) miss_cnt <= miss_cnt + 1'b1;
  end

  assert_miss_below_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (miss_cnt < CW'(LIMIT)));

endmodule

// File: rtl/nor_flash_seq.sv
module nor_flash_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned AW         = 18,
  parameter int unsigned DW         = 16,
  parameter int unsigned CLK_NS     = 8,
  parameter int unsigned AS_NS      = 10,
  parameter int unsigned WP_NS      = 90,
  parameter int unsigned WPH_NS     = 90,
  parameter int unsigned DS_NS      = 50,
  parameter int unsigned AH_NS      = 50,
  parameter int unsigned ACC_NS     = 90,
  parameter int unsigned POLL_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic          rsp_timeout,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_i
);

  localparam int unsigned SETUP_C = ns_to_cyc(AS_NS, CLK_NS);
  localparam int unsigned LOW_C   = max_u(ns_to_cyc(WP_NS, CLK_NS), ns_to_cyc(DS_NS, CLK_NS));
  localparam int unsigned HIGH_C  = max_u(ns_to_cyc(WPH_NS, CLK_NS), ns_to_cyc(AH_NS, CLK_NS));
  localparam int unsigned RD_C    = ns_to_cyc(ACC_NS, CLK_NS);

  seq_st_e       st;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    step_q;
  logic          inflight;

  logic          accept;
  logic          eng_start, eng_rd, eng_done, eng_idle;
  logic [AW-1:0] eng_addr, c_addr;
  logic [DW-1:0] c_data, eng_rdata;
  logic          c_last;
  logic          poll_hit, poll_expire, verify_ok;

  function automatic logic [DW-1:0] final_word(input op_e o, input logic [DW-1:0] d);
    return (o == OP_PROG) ? d : '1;
  endfunction

  function automatic logic done_bit(input op_e o, input logic [DW-1:0] d);
    return (o == OP_PROG) ? d[7] : 1'b1;
  endfunction

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign eng_start = (st != ST_IDLE) && !inflight;
  assign eng_rd    = (st != ST_CMD);
  assign eng_addr  = (st == ST_CMD) ? c_addr : addr_q;
  assign verify_ok = (eng_rdata == final_word(op_q, data_q));

  flash_cmd_table #(.AW(AW), .DW(DW)) u_table (
    .op       (op_q),
    .step     (step_q),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .c_addr   (c_addr),
    .c_data   (c_data),
    .c_last   (c_last)
  );

  flash_bus_cycle #(
    .AW(AW), .DW(DW), .SETUP_C(SETUP_C), .LOW_C(LOW_C), .HIGH_C(HIGH_C), .RD_C(RD_C)
  ) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eng_start),
    .is_rd   (eng_rd),
    .addr    (eng_addr),
    .wdata   (c_data),
    .done    (eng_done),
    .idle    (eng_idle),
    .rdata   (eng_rdata),
    .f_ce_n  (fl_ce_n),
    .f_oe_n  (fl_oe_n),
    .f_we_n  (fl_we_n),
    .f_addr  (fl_addr),
    .f_dq_o  (fl_dq_o),
    .f_dq_oe (fl_dq_oe),
    .f_dq_in (fl_dq_i)
  );

  flash_poll_ctl #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (st != ST_POLL),
    .rd_done (eng_done && inflight && (st == ST_POLL)),
    .rd_b7   (eng_rdata[7]),
    .exp_b7  (done_bit(op_q, data_q)),
    .hit     (poll_hit),
    .expire  (poll_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      op_q        <= OP_PROG;
      addr_q      <= '0;
      data_q      <= '0;
      step_q      <= '0;
      inflight    <= 1'b0;
      rsp_done    <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_timeout <= 1'b0;
    end else begin
      rsp_done    <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_timeout <= 1'b0;
      if (st == ST_IDLE) begin
        if (accept) begin
          if (op_e'(req_op) == OP_BAD) begin
            rsp_err <= 1'b1;
          end else begin
            op_q     <= op_e'(req_op);
            addr_q   <= req_addr;
            data_q   <= req_data;
            step_q   <= '0;
            inflight <= 1'b0;
            st       <= ST_CMD;
          end
        end
      end else if (eng_start) begin
        inflight <= 1'b1;
      end else if (eng_done) begin
        inflight <= 1'b0;
        unique case (st)
          ST_CMD: begin
            if (c_last) st <= ST_POLL;
            else step_q <= step_q + 1'b1;
          end
          ST_POLL: begin
            if (poll_hit) st <= ST_VERIFY;
            else if (poll_expire) begin
              rsp_err     <= 1'b1;
              rsp_timeout <= 1'b1;
              st          <= ST_IDLE;
            end
          end
          default: begin
            if (verify_ok) rsp_done <= 1'b1;
            else rsp_err <= 1'b1;
            st <= ST_IDLE;
          end
        endcase
      end
    end
  end

  assert_start_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_idle);

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_op != 2'd3)) |=> !req_ready);

  assert_bad_op_rejected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_op == 2'd3)) |=> (rsp_err && !rsp_timeout && fl_ce_n));

  assert_rsp_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_err));

  assert_timeout_is_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> rsp_err);

  assert_hit_goes_verify_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_POLL) && poll_hit) |=> (st == ST_VERIFY));

  assert_poll_reads_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_oe_n) |-> (fl_addr == addr_q));

endmodule

// File: tb/tb_nor_flash_seq.sv
`timescale 1ns/1ps
module tb_nor_flash_seq;

  localparam int AW = 18;
  localparam int DW = 16;
  localparam int PL = 40;
  localparam int T_LO = (90 + 7) / 8;
  localparam int T_HI = (90 + 7) / 8;
  localparam int T_RD = (90 + 7) / 8;

  typedef struct packed {
    logic [1:0]  op;
    logic [17:0] addr;
    logic [15:0] data;
    logic [31:0] busy;
    logic [15:0] corrupt;
    logic [1:0]  kind;   // 0 done, 1 mismatch error, 2 timeout
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 18'h01234, 16'h5A80, 32'd3,    16'h0000, 2'd0},
    '{2'd0, 18'h3FFFF, 16'h0011, 32'd0,    16'h0000, 2'd0},
    '{2'd1, 18'h05000, 16'h0000, 32'd5,    16'h0000, 2'd0},
    '{2'd2, 18'h00000, 16'h0000, 32'd2,    16'h0000, 2'd0},
    '{2'd0, 18'h2AAAA, 16'hC3C3, 32'd1,    16'h0100, 2'd1},
    '{2'd1, 18'h03000, 16'h0000, 32'd1000, 16'h0000, 2'd2},
    '{2'd0, 18'h10001, 16'h007F, 32'd39,   16'h0000, 2'd0},
    '{2'd0, 18'h10002, 16'hFFFF, 32'd40,   16'h0000, 2'd2},
    '{2'd2, 18'h00123, 16'h0000, 32'd0,    16'h0001, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic rsp_done, rsp_err, rsp_timeout;
  logic fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_o, fl_dq_i;

  nor_flash_seq #(.AW(AW), .DW(DW), .POLL_LIMIT(PL)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_timeout(rsp_timeout),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit wd_fired = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Flash model: busy for a given number of reads, then a final word.
  int            busy_reads = 0;
  logic [15:0]   busy_word = '0;
  logic [15:0]   final_word = '0;
  int            rd_base = 0;
  logic [AW-1:0] rd_tgt = '0;
  int            rd_cnt = 0;

  assign fl_dq_i = (!fl_ce_n && !fl_oe_n) ?
                   (((rd_cnt - rd_base) < busy_reads) ? busy_word : final_word) : 16'h0000;

  // Bus monitor, sampled on the falling clock edge.
  logic [AW-1:0] wa [1024];
  logic [DW-1:0] wd [1024];
  int wr_cnt = 0, tviol = 0, addr_viol = 0;
  int lo_run = 0, hi_run = 0, oe_run = 0;
  bit we_p = 1'b1, oe_p = 1'b1, have_rise = 1'b0;
  logic [AW-1:0] fall_a = '0, rise_a = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      we_p = 1'b1; oe_p = 1'b1; have_rise = 1'b0;
      lo_run = 0; hi_run = 0; oe_run = 0;
    end else begin
      if ((!fl_we_n || !fl_oe_n) && fl_ce_n) tviol++;
      if (!fl_we_n && !fl_oe_n) tviol++;
      if (!fl_we_n) begin
        if (we_p) begin
          fall_a = fl_addr;
          if (have_rise && hi_run < T_HI) tviol++;
        end
        if (!fl_dq_oe) tviol++;
        lo_run++;
      end else begin
        if (!we_p) begin
          if (lo_run < T_LO) tviol++;
          if (fl_addr != fall_a) tviol++;
          wa[wr_cnt % 1024] = fall_a;
          wd[wr_cnt % 1024] = fl_dq_o;
          wr_cnt++;
          have_rise = 1'b1;
          hi_run = 0;
          rise_a = fl_addr;
        end
        lo_run = 0;
        hi_run++;
        if (have_rise && hi_run <= T_HI && fl_addr != rise_a) tviol++;
      end
      if (!fl_oe_n) begin
        oe_run++;
        if (fl_dq_oe) tviol++;
        if (fl_addr != rd_tgt) addr_viol++;
      end else begin
        if (!oe_p) begin
          if (oe_run < T_RD) tviol++;
          rd_cnt++;
        end
        oe_run = 0;
      end
      we_p = fl_we_n;
      oe_p = fl_oe_n;
    end
  end

  function automatic logic [33:0] exp_wr(input logic [1:0] op, input int i,
                                         input logic [17:0] a, input logic [15:0] d);
    logic [17:0] ea;
    logic [15:0] ed;
    case (i)
      0: begin ea = 18'h05555; ed = 16'h00AA; end
      1: begin ea = 18'h02AAA; ed = 16'h0055; end
      2: begin ea = 18'h05555; ed = (op == 2'd0) ? 16'h00A0 : 16'h0080; end
      3: begin
        if (op == 2'd0) begin ea = a; ed = d; end
        else begin ea = 18'h05555; ed = 16'h00AA; end
      end
      4: begin ea = 18'h02AAA; ed = 16'h0055; end
      default: begin
        if (op == 2'd1) begin ea = a; ed = 16'h0030; end
        else begin ea = 18'h05555; ed = 16'h0010; end
      end
    endcase
    return {ea, ed};
  endfunction

  function automatic string seq_req(input logic [1:0] op);
    return (op == 2'd0) ? "R1" : (op == 2'd1) ? "R2" : "R3";
  endfunction

  task automatic run_op(input vec_t v);
    int wb, tb0, ab0, cyc, nlen, nrd, extra;
    bit got_d, got_e, got_t, rdy;
    string rq;
    rq = seq_req(v.op);
    busy_reads = int'(v.busy);
    busy_word  = (v.op == 2'd0) ? (v.data ^ 16'h0080) : 16'h0000;
    final_word = ((v.op == 2'd0) ? v.data : 16'hFFFF) ^ v.corrupt;
    rd_tgt  = v.addr;
    rd_base = rd_cnt;
    wb = wr_cnt; tb0 = tviol; ab0 = addr_viol;
    @(negedge clk);
    req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_data = v.data;
    @(negedge clk);
    rdy = req_ready;
    // Hold a different request while busy: it must be ignored.
    req_op = 2'd3; req_addr = '1; req_data = 16'hDEAD;
    chk(!rdy, "R8", "ready low after accept", rdy, 0);
    cyc = 0;
    while (!(rsp_done || rsp_err) && cyc < 5000 && !wd_fired) begin
      @(negedge clk);
      cyc++;
    end
    got_d = rsp_done; got_e = rsp_err; got_t = rsp_timeout;
    req_valid = 1'b0;
    chk(got_d == (v.kind == 2'd0), (v.kind == 2'd2) ? "R7" : "R6", "done pulse", got_d, v.kind == 2'd0);
    chk(got_e == (v.kind != 2'd0), (v.kind == 2'd2) ? "R7" : "R6", "err pulse", got_e, v.kind != 2'd0);
    chk(got_t == (v.kind == 2'd2), "R7", "timeout flag", got_t, v.kind == 2'd2);
    nlen = (v.op == 2'd0) ? 4 : 6;
    chk((wr_cnt - wb) == nlen, rq, "write count", wr_cnt - wb, nlen);
    for (int i = 0; i < nlen && i < (wr_cnt - wb); i++) begin
      chk({wa[(wb + i) % 1024], wd[(wb + i) % 1024]} == exp_wr(v.op, i, v.addr, v.data),
          rq, $sformatf("write %0d addr/data", i),
          {wa[(wb + i) % 1024], wd[(wb + i) % 1024]}, exp_wr(v.op, i, v.addr, v.data));
    end
    nrd = (v.kind == 2'd2) ? PL : int'(v.busy) + 2;
    chk((rd_cnt - rd_base) == nrd, (v.kind == 2'd2) ? "R7" : "R5", "read count", rd_cnt - rd_base, nrd);
    chk(addr_viol == ab0, "R5", "read address", addr_viol - ab0, 0);
    chk(tviol == tb0, "R4", "write/read timing", tviol - tb0, 0);
    extra = 0;
    repeat (6) begin
      @(negedge clk);
      if (rsp_done || rsp_err || !fl_ce_n || !req_ready) extra++;
    end
    chk(extra == 0, "R8", "quiet after response", extra, 0);
  endtask

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !wd_fired) begin
      wd_fired = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R10", "strobes in reset", {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
    chk(!fl_dq_oe, "R10", "bus released in reset", fl_dq_oe, 0);
    chk(req_ready, "R10", "ready in reset", req_ready, 1);
    chk(!rsp_done && !rsp_err && !rsp_timeout, "R10", "no response in reset",
        {rsp_done, rsp_err, rsp_timeout}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: invalid code
    begin
      int wb;
      wb = wr_cnt;
      req_valid = 1'b1; req_op = 2'd3; req_addr = 18'h00100; req_data = 16'h1234;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_err && !rsp_timeout && !rsp_done, "R9", "bad op error pulse",
          {rsp_done, rsp_err, rsp_timeout}, 3'b010);
      chk(fl_ce_n && req_ready, "R9", "no bus cycle, still ready", {fl_ce_n, req_ready}, 2'b11);
      repeat (20) @(negedge clk);
      chk(wr_cnt == wb && !rsp_err, "R9", "nothing written", wr_cnt - wb, 0);
    end

    // Table walk
    for (int k = 0; k < NV; k++) run_op(VEC[k]);

    // R10: reset in the middle of a write sequence
    begin
      int wb;
      wb = wr_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd1; req_addr = 18'h05000; req_data = 16'h0000;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (40) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R10", "bus idle after mid reset",
          {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
      chk(req_ready, "R10", "ready after mid reset", req_ready, 1);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (30) @(negedge clk);
      chk(fl_ce_n && !rsp_done && !rsp_err && (wr_cnt - wb) < 6, "R10", "operation abandoned",
          wr_cnt - wb, 0);
      run_op(VEC[0]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule